// File: doc/BRIEF.md
# Infrared Carrier Transmit/Receive Timer

This block drives and measures infrared remote-control signalling. In transmit mode it builds a carrier from a programmable high count and low count, then shapes the line one interval at a time. Each interval lasts a programmed number of carrier cycles. A data bit decides whether the interval carries the carrier or holds the line at its idle level. A polarity input sets both the idle level and the sense of the carrier. The carrier counts, the interval length and the data bit are held in shadow registers. They are reloaded only when an interval finishes, so software may write the next symbol at any time during the current one. A one-cycle pulse marks every interval boundary, so the next symbol can be written in time.

In receive mode the same block counts clock cycles from the moment it is enabled. On each input edge that the edge selector accepts, it captures the running count and raises a sticky capture flag. It can optionally restart the count from zero at that edge, which gives pulse-width measurement. A count that wraps past its maximum before a qualifying edge raises a sticky overflow flag. A dedicated clear input drops both flags.

Configuration and status are plain parallel pins. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. Captured values are sampled when the capture flag is seen, and the flag is then cleared.

Top module: `ir_timer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, ir_out equals polarity, and interval_irq, cap_flag, ovf_flag and cap_value are all zero.
- R2: When transmission is not running, ir_out follows the polarity input directly (idle level = polarity).
- R3: Transmission starts when enable=1 and mode_tx=1 are seen at a clock edge. The first interval begins on the next cycle. With data_bit=1 its first cycle drives the active level, which is the inverse of polarity.
- R4: A carrier cycle is a high phase of car_hi+1 clocks (ir_out = ~polarity when data is 1) followed by a low phase of car_lo+1 clocks (ir_out = polarity).
- R5: An interval lasts mod_count+1 whole carrier cycles. With data_bit=0, ir_out stays at polarity for the whole interval.
- R6: car_hi, car_lo, mod_count and data_bit are sampled only when transmission starts and on the last clock of each interval. Changes at other times have no effect on the current interval.
- R7: interval_irq is a single-cycle pulse on the first cycle of every interval that follows a completed one. It is never raised for the first interval after a start, and never in receive mode.
- R8: In receive mode (enable=1, mode_tx=0) the counter starts at 0 and advances every clock. edge_sel encodes 00 = no edge qualifies, 01 = rising, 10 = falling, 11 = both. An edge means ir_in differs from its value one cycle earlier. On a qualifying edge, cap_value takes the count held before that edge, and cap_flag sets.
- R9: With reload=1, a qualifying edge restarts the count at 0. With reload=0 the count continues to advance.
- R10: If the counter wraps from all-ones to zero without being reloaded by a qualifying edge in that cycle, ovf_flag sets.
- R11: cap_flag and ovf_flag stay set until a cycle with flag_clr=1. A flag being set in the same cycle as the clear stays set. cap_value does not change outside receive mode.
- R12: Dropping enable, or switching mode_tx to 0, returns ir_out to idle on the next cycle. A later start begins a fresh interval with freshly sampled settings and no interval_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable for the selected mode |
| mode_tx | input | 1 | 1 = transmit, 0 = receive |
| polarity | input | 1 | Idle level and inverse of the active carrier level |
| car_hi | input | CNT_W | Carrier high phase length minus one |
| car_lo | input | CNT_W | Carrier low phase length minus one |
| mod_count | input | CNT_W | Interval length in carrier cycles minus one |
| data_bit | input | 1 | 1 = send carrier, 0 = hold idle for the interval |
| edge_sel | input | 2 | Receive edge qualifier |
| reload | input | 1 | Restart count at 0 on each capture |
| ir_in | input | 1 | Receive line, already synchronised |
| flag_clr | input | 1 | Clears cap_flag and ovf_flag |
| ir_out | output | 1 | Transmit line |
| interval_irq | output | 1 | Pulse at each interval boundary |
| cap_flag | output | 1 | Sticky capture flag |
| cap_value | output | CNT_W | Last captured count |
| ovf_flag | output | 1 | Sticky overflow flag (interrupt) |

## Verification
The hardest condition to reach is the counter wrap in receive mode. It needs 2^16 clocks with no qualifying edge. The stimulus parks edge_sel at 00 while ir_in keeps toggling, so the edges must be ignored for overflow to appear. A second hard case is a settings change in the middle of an interval. The stimulus rewrites every shadowed input a few clocks into an interval, then compares each cycle against a model that counts position within an interval, not phase counters.

// File: rtl/ir_timer_pkg.sv
package ir_timer_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/ir_carrier_gen.sv
// Carrier phase generator: high phase hi+1 clocks, low phase lo+1 clocks (R4)
module ir_carrier_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] restart_hi,
  input  logic [CNT_W-1:0] hi_val,
  input  logic [CNT_W-1:0] lo_val,
  output logic             in_hi,
  output logic             cyc_end
);
  logic [CNT_W-1:0] ph_cnt;

  assign cyc_end = run && !in_hi && (ph_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_hi  <= 1'b0;
      ph_cnt <= '0;
    end else if (restart) begin
      in_hi  <= 1'b1;
      ph_cnt <= restart_hi;
    end else if (run) begin
      if (ph_cnt != '0) begin
        ph_cnt <= ph_cnt - 1'b1;
      end else if (in_hi) begin
        in_hi  <= 1'b0;
        ph_cnt <= lo_val;
      end else begin
        in_hi  <= 1'b1;
        ph_cnt <= hi_val;
      end
    end
  end
endmodule

// File: rtl/ir_tx_seq.sv
// Interval sequencer with shadowed settings (R3, R5, R6, R7, R12)
module ir_tx_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] hi_in,
  input  logic [CNT_W-1:0] lo_in,
  input  logic [CNT_W-1:0] mod_in,
  input  logic             data_in,
  input  logic             cyc_end,
  output logic             tx_run,
  output logic             restart,
  output logic [CNT_W-1:0] hi_sh,
  output logic [CNT_W-1:0] lo_sh,
  output logic             data_sh,
  output logic             interval_irq
);
  logic [CNT_W-1:0] cyc_left;
  logic             last_cyc;

  assign last_cyc = cyc_end && (cyc_left == '0);
  assign restart  = go && (!tx_run || last_cyc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_run       <= 1'b0;
      interval_irq <= 1'b0;
      cyc_left     <= '0;
      hi_sh        <= '0;
      lo_sh        <= '0;
      data_sh      <= 1'b0;
    end else if (!go) begin
      tx_run       <= 1'b0;
      interval_irq <= 1'b0;
    end else begin
      tx_run       <= 1'b1;
      interval_irq <= tx_run && last_cyc;
      if (restart) begin
        hi_sh    <= hi_in;
        lo_sh    <= lo_in;
        data_sh  <= data_in;
        cyc_left <= mod_in;
      end else if (cyc_end) begin
        cyc_left <= cyc_left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ir_rx_capture.sv
// Receive edge counter with capture, reload and overflow (R8-R11)
module ir_rx_capture
  import ir_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [1:0]       edge_sel,
  input  logic             reload,
  input  logic             ir_in,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_flag,
  output logic             ovf_flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  edge_sel_e        sel;
  logic             ir_prev;
  logic [CNT_W-1:0] cnt;
  logic             rise, fall, qual, wrap;

  assign sel  = edge_sel_e'(edge_sel);
  assign rise = ir_in && !ir_prev;
  assign fall = !ir_in && ir_prev;

  always_comb begin
    unique case (sel)
      EDGE_RISE: qual = rise;
      EDGE_FALL: qual = fall;
      EDGE_BOTH: qual = rise || fall;
      default:   qual = 1'b0;
    endcase
    qual = qual && go;
  end

  assign wrap = go && (cnt == CNT_MAX) && !(qual && reload);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_prev   <= 1'b0;
      cnt       <= '0;
      cap_value <= '0;
      cap_flag  <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      ir_prev <= ir_in;
      if (!go)
        cnt <= '0;
      else if (qual && reload)
        cnt <= '0;
      else
        cnt <= cnt + 1'b1;
      if (qual)
        cap_value <= cnt;
      if (qual)
        cap_flag <= 1'b1;
      else if (flag_clr)
        cap_flag <= 1'b0;
      if (wrap)
        ovf_flag <= 1'b1;
      else if (flag_clr)
        ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ir_timer.sv
module ir_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             mode_tx,
  input  logic             polarity,
  input  logic [CNT_W-1:0] car_hi,
  input  logic [CNT_W-1:0] car_lo,
  input  logic [CNT_W-1:0] mod_count,
  input  logic             data_bit,
  input  logic [1:0]       edge_sel,
  input  logic             reload,
  input  logic             ir_in,
  input  logic             flag_clr,
  output logic             ir_out,
  output logic             interval_irq,
  output logic             cap_flag,
  output logic [CNT_W-1:0] cap_value,
  output logic             ovf_flag
);
  logic             go_tx, go_rx;
  logic             tx_run, restart, in_hi, cyc_end, data_sh;
  logic [CNT_W-1:0] hi_sh, lo_sh;

  assign go_tx = enable && mode_tx;
  assign go_rx = enable && !mode_tx;

  ir_tx_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go_tx),
    .hi_in(car_hi), .lo_in(car_lo), .mod_in(mod_count), .data_in(data_bit),
    .cyc_end(cyc_end), .tx_run(tx_run), .restart(restart),
    .hi_sh(hi_sh), .lo_sh(lo_sh), .data_sh(data_sh),
    .interval_irq(interval_irq)
  );

  ir_carrier_gen #(.CNT_W(CNT_W)) u_car (
    .clk(clk), .rst_n(rst_n), .run(tx_run), .restart(restart),
    .restart_hi(car_hi), .hi_val(hi_sh), .lo_val(lo_sh),
    .in_hi(in_hi), .cyc_end(cyc_end)
  );

  ir_rx_capture #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .go(go_rx), .edge_sel(edge_sel),
    .reload(reload), .ir_in(ir_in), .flag_clr(flag_clr),
    .cap_value(cap_value), .cap_flag(cap_flag), .ovf_flag(ovf_flag)
  );

  // R2, R4: idle level is polarity, active carrier phase is its inverse
  assign ir_out = polarity ^ (tx_run && data_sh && in_hi);
endmodule

// File: rtl/ir_timer_chk.sv
module ir_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             mode_tx,
  input logic             polarity,
  input logic             flag_clr,
  input logic             ir_out,
  input logic             interval_irq,
  input logic             cap_flag,
  input logic [CNT_W-1:0] cap_value,
  input logic             ovf_flag
);
  // R12
  idle_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable && mode_tx) |-> (ir_out == polarity));

  // R7
  irq_tx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    interval_irq |-> $past(enable && mode_tx));

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    interval_irq |=> !interval_irq);

  // R8
  cap_in_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_flag) |-> $past(enable && !mode_tx));

  // R11
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable && !mode_tx) |=> $stable(cap_value));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  // R11
  cap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !flag_clr) |=> cap_flag);
endmodule

bind ir_timer ir_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .mode_tx(mode_tx),
  .polarity(polarity), .flag_clr(flag_clr), .ir_out(ir_out),
  .interval_irq(interval_irq), .cap_flag(cap_flag),
  .cap_value(cap_value), .ovf_flag(ovf_flag)
);

// File: tb/ir_timer_tb.sv
`timescale 1ns/1ps
module ir_timer_tb;
  localparam int CW = 16;
  localparam int MAXC = 65535;

  logic clk = 0, rst_n = 0;
  logic enable = 0, mode_tx = 0, polarity = 0, data_bit = 0;
  logic [CW-1:0] car_hi = 0, car_lo = 0, mod_count = 0;
  logic [1:0] edge_sel = 0;
  logic reload = 0, ir_in = 0, flag_clr = 0;
  logic ir_out, interval_irq, cap_flag, ovf_flag;
  logic [CW-1:0] cap_value;

  always #4 clk = ~clk;

  ir_timer #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_tx(mode_tx),
    .polarity(polarity), .car_hi(car_hi), .car_lo(car_lo),
    .mod_count(mod_count), .data_bit(data_bit), .edge_sel(edge_sel),
    .reload(reload), .ir_in(ir_in), .flag_clr(flag_clr), .ir_out(ir_out),
    .interval_irq(interval_irq), .cap_flag(cap_flag),
    .cap_value(cap_value), .ovf_flag(ovf_flag)
  );

  int vecs = 0, bad = 0;
  string cur_req = "R1";
  bit finished = 0;

  // reference model state
  bit m_run = 0, m_dsh = 0, m_irq = 0;
  int m_pos = 0, m_h = 0, m_l = 0, m_m = 0;
  int m_cnt = 0, m_capv = 0;
  bit m_capf = 0, m_ovf = 0, m_prev = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_pos = 0; m_irq = 0; m_dsh = 0;
      m_cnt = 0; m_capv = 0; m_capf = 0; m_ovf = 0; m_prev = 0;
    end else begin
      bit go, gr, q, sc, so, ri, fa;
      go = enable && mode_tx;
      m_irq = 0;
      if (!go) m_run = 0;
      else if (!m_run) begin
        m_run = 1; m_pos = 0;
        m_h = car_hi; m_l = car_lo; m_m = mod_count; m_dsh = data_bit;
      end else if (m_pos == (m_h + m_l + 2) * (m_m + 1) - 1) begin
        m_pos = 0; m_irq = 1;
        m_h = car_hi; m_l = car_lo; m_m = mod_count; m_dsh = data_bit;
      end else m_pos++;
      gr = enable && !mode_tx;
      ri = ir_in && !m_prev;
      fa = !ir_in && m_prev;
      q = gr && ((edge_sel[0] && ri) || (edge_sel[1] && fa));
      sc = 0; so = 0;
      if (!gr) m_cnt = 0;
      else if (q) begin
        m_capv = m_cnt; sc = 1;
        if (reload) m_cnt = 0;
        else begin so = (m_cnt == MAXC); m_cnt = (m_cnt + 1) % (MAXC + 1); end
      end else begin
        so = (m_cnt == MAXC); m_cnt = (m_cnt + 1) % (MAXC + 1);
      end
      m_capf = sc ? 1'b1 : (flag_clr ? 1'b0 : m_capf);
      m_ovf  = so ? 1'b1 : (flag_clr ? 1'b0 : m_ovf);
      m_prev = ir_in;
    end
  end

  task automatic chk(string nm, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", cur_req, nm, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (!finished) begin
      bit eo;
      eo = polarity ^ (m_run && m_dsh && ((m_pos % (m_h + m_l + 2)) < m_h + 1));
      chk("ir_out", ir_out, eo);
      chk("interval_irq", interval_irq, m_irq);
      chk("cap_flag", cap_flag, m_capf);
      chk("cap_value", cap_value, m_capv);
      chk("ovf_flag", ovf_flag, m_ovf);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired during %s", cur_req);
    finish_run();
  end

  initial begin
    cur_req = "R1"; polarity = 1;
    tick(3);
    rst_n = 1; tick(2);
    cur_req = "R2"; polarity = 0; tick(2); polarity = 1; tick(2); polarity = 0; tick(2);
    // basic carrier: hi=2 lo=1, 4 cycles per interval
    cur_req = "R3 R4 R5 R7";
    car_hi = 2; car_lo = 1; mod_count = 3; data_bit = 1;
    enable = 1; mode_tx = 1;
    tick(60);
    // mid-interval rewrite of every shadowed setting
    cur_req = "R6";
    tick(3);
    car_hi = 0; car_lo = 3; mod_count = 1; data_bit = 0;
    tick(40);
    data_bit = 1; tick(5); car_hi = 4; tick(40);
    // idle data with inverted polarity
    cur_req = "R5 data0";
    polarity = 1; data_bit = 0; tick(30);
    data_bit = 1; car_hi = 0; car_lo = 0; mod_count = 0; tick(20);
    // stop and restart
    cur_req = "R12";
    enable = 0; tick(5);
    car_hi = 1; car_lo = 2; mod_count = 2; enable = 1; tick(30);
    mode_tx = 0; tick(4); mode_tx = 1; tick(20);
    enable = 0; polarity = 0; tick(3);
    // receive
    cur_req = "R8 rising";
    mode_tx = 0; edge_sel = 2'b01; reload = 0; enable = 1;
    for (int i = 0; i < 6; i++) begin tick(3 + i); ir_in = ~ir_in; end
    cur_req = "R8 falling";
    edge_sel = 2'b10;
    for (int i = 0; i < 6; i++) begin tick(2 + i); ir_in = ~ir_in; end
    cur_req = "R8 both R9";
    edge_sel = 2'b11; reload = 1;
    for (int i = 0; i < 8; i++) begin tick(4 + (i % 3)); ir_in = ~ir_in; end
    cur_req = "R8 none";
    edge_sel = 2'b00;
    for (int i = 0; i < 4; i++) begin tick(3); ir_in = ~ir_in; end
    cur_req = "R11 clear";
    flag_clr = 1; tick(1); flag_clr = 0; tick(3);
    edge_sel = 2'b11; ir_in = ~ir_in; flag_clr = 1; tick(1); flag_clr = 0; tick(3);
    mode_tx = 1; enable = 0; ir_in = ~ir_in; tick(4);
    // overflow with ignored edges
    cur_req = "R10";
    mode_tx = 0; enable = 1; edge_sel = 2'b00; reload = 0;
    for (int i = 0; i < 660; i++) begin tick(100); ir_in = ~ir_in; end
    tick(10);
    cur_req = "R11 ovf";
    tick(5); flag_clr = 1; tick(1); flag_clr = 0; tick(5);
    finish_run();
  end
endmodule